// File: doc/BRIEF.md
# DRAM Reclocking Command Sequencer

This block walks a DRAM device through a change of its input clock frequency without losing stored data. After a start pulse it latches the memory type together with the present and the wanted values of mode registers 0, 1 and 2. It then parks the device in self-refresh, asks for the clock change, brings the device back and rewrites only those mode registers whose value changes. Depending on the wanted DLL setting, it either turns the DLL off before self-refresh or resets the DLL and waits for it to lock afterwards.

Commands leave on one port with a valid/ready handshake. The clock change and the timing-register update are separate request/acknowledge pairs, and the block waits for each acknowledge before it goes on. Timed gaps between steps come from a cycle counter. Each gap is a nanosecond parameter converted to clock cycles and rounded up.

Top module: `dram_reclock_seq`

## Requirements
- R1: The `mem_type` input selects the memory type: 0 is DDR2, 1 is DDR3 and 2 is GDDR3. A start with type 3 raises `error` for one cycle, in the cycle after start is sampled, and issues no command and no request.
- R2: In idle, a start pulse launches a run. `busy` stays high from the cycle after start until the block returns to idle. `done` is a one-cycle pulse that ends a successful run. Start, and any change on the type or register inputs, has no effect while `busy` is high.
- R3: A command stays on the port, with `cmd_op`, `cmd_sel` and `cmd_data` stable, until `cmd_ready` accepts it. The `cmd_op` codes are: precharge 0, refresh 1, auto-refresh off 2, auto-refresh on 3, self-refresh on 4, self-refresh off 5, mode-register write 6. For a mode-register write, `cmd_sel` is the register number and `cmd_data` is the value. For every other command both are zero.
- R4: The DLL-off bit of MR1 is bit 0 for DDR2 and DDR3, and bit 6 for GDDR3. The block checks whether that bit is clear in the present MR1 and set in the wanted MR1. When both hold, the run begins with a precharge, then writes MR1 with the present value plus the DLL-off bit, then waits the mode-register delay.
- R5: Self-refresh is entered with this order: precharge, refresh, refresh, auto-refresh off, self-refresh on. The self-refresh entry delay follows.
- R6: The block then raises `clk_req` and holds it until `clk_ack` is seen.
- R7: After the acknowledge, the block waits the self-refresh exit delay. It then issues precharge, self-refresh off and auto-refresh on, and waits the exit-to-command delay.
- R8: Mode registers are written in the order MR2, MR1, MR0. A register is written with its wanted value only when that value differs from the present one, and each write is followed by the mode-register delay. MR2 is compared and written for DDR3 only.
- R9: After the mode-register writes, `tim_req` is raised and held until `tim_ack` is seen.
- R10: If the DLL-off bit is clear in the wanted MR1, the block runs a DLL reset. It writes MR0 with the wanted value and bit 8 set, waits the mode-register delay, then writes MR0 with the wanted value. It then waits the mode-register delay plus the DLL lock time. On GDDR3 a last precharge follows.
- R11: Each delay lasts ceil(ns / CLK_NS) cycles, and a delay of zero costs no cycle. The mode-register delay is 1000 ns. The DLL lock time is 2000 ns for DDR2, 12000 ns for DDR3 and 40000 ns for GDDR3. The self-refresh entry, self-refresh exit and exit-to-command delays are parameters that default to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a run (used only in idle) |
| mem_type | input | 2 | Memory type code |
| cur_mr0 | input | MRW | Present MR0 value |
| cur_mr1 | input | MRW | Present MR1 value |
| cur_mr2 | input | MRW | Present MR2 value (used by DDR3 only) |
| tgt_mr0 | input | MRW | Wanted MR0 value |
| tgt_mr1 | input | MRW | Wanted MR1 value |
| tgt_mr2 | input | MRW | Wanted MR2 value |
| busy | output | 1 | Run in progress |
| done | output | 1 | Successful end, one cycle |
| error | output | 1 | Unsupported type, one cycle |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command accepted |
| cmd_op | output | 3 | Command code |
| cmd_sel | output | 2 | Mode-register number |
| cmd_data | output | MRW | Mode-register value |
| clk_req | output | 1 | Clock-change request |
| clk_ack | input | 1 | Clock change finished |
| tim_req | output | 1 | Timing-update request |
| tim_ack | input | 1 | Timing update finished |

## Verification
Every accepted command, accepted request, `done` and `error` is treated as one event. When the handshakes are answered at once, the next event comes exactly one cycle plus the cycles of any delay between them after the previous one. The first event comes one cycle after start is sampled. For each run the scoreboard computes the expected events and their spacing in cycles from the memory type, the register values and the rounded delays. The monitor compares each event in the cycle it happens. In runs with random stalls only the order and the contents are compared, because the spacing then depends on the stalls.

// File: rtl/dram_reclock_seq.sv
module dram_reclock_seq #(
  parameter int CLK_NS        = 20,
  parameter int MRD_NS        = 1000,
  parameter int SRE_NS        = 0,
  parameter int SRX_NS        = 0,
  parameter int XS_NS         = 0,
  parameter int DLLK_DDR2_NS  = 2000,
  parameter int DLLK_DDR3_NS  = 12000,
  parameter int DLLK_GDDR3_NS = 40000,
  parameter int MRW           = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [1:0]     mem_type,
  input  logic [MRW-1:0] cur_mr0,
  input  logic [MRW-1:0] cur_mr1,
  input  logic [MRW-1:0] cur_mr2,
  input  logic [MRW-1:0] tgt_mr0,
  input  logic [MRW-1:0] tgt_mr1,
  input  logic [MRW-1:0] tgt_mr2,
  output logic           busy,
  output logic           done,
  output logic           error,
  output logic           cmd_valid,
  input  logic           cmd_ready,
  output logic [2:0]     cmd_op,
  output logic [1:0]     cmd_sel,
  output logic [MRW-1:0] cmd_data,
  output logic           clk_req,
  input  logic           clk_ack,
  output logic           tim_req,
  input  logic           tim_ack
);
  localparam int MRD_C  = (MRD_NS + CLK_NS - 1) / CLK_NS;
  localparam int SRE_C  = (SRE_NS + CLK_NS - 1) / CLK_NS;
  localparam int SRX_C  = (SRX_NS + CLK_NS - 1) / CLK_NS;
  localparam int XS_C   = (XS_NS + CLK_NS - 1) / CLK_NS;
  localparam int DK2_C  = (DLLK_DDR2_NS + CLK_NS - 1) / CLK_NS;
  localparam int DK3_C  = (DLLK_DDR3_NS + CLK_NS - 1) / CLK_NS;
  localparam int DKG_C  = (DLLK_GDDR3_NS + CLK_NS - 1) / CLK_NS;
  localparam int DKMAX  = (DK2_C > DK3_C) ? ((DK2_C > DKG_C) ? DK2_C : DKG_C)
                                          : ((DK3_C > DKG_C) ? DK3_C : DKG_C);
  localparam int MAXW   = MRD_C + DKMAX + SRE_C + SRX_C + XS_C;
  localparam int WW     = $clog2(MAXW + 2);
  localparam int NS     = 30;

  typedef enum logic [4:0] {
    S_IDLE, S_DOFF_PRE, S_DOFF_MRS, S_DOFF_W,
    S_SR_PRE, S_SR_REF1, S_SR_REF2, S_SR_AOFF, S_SR_SON, S_SR_W,
    S_CLK, S_SRX_W, S_X_PRE, S_X_SOFF, S_X_AON, S_XS_W,
    S_MR2, S_MR2_W, S_MR1, S_MR1_W, S_MR0, S_MR0_W, S_TIM,
    S_RST_A, S_RST_W1, S_RST_B, S_RST_W2, S_RST_PRE,
    S_DONE, S_ERR
  } st_t;

  st_t st, nx, adv;
  logic [WW-1:0]  wcnt;
  logic [1:0]     typ_q;
  logic [MRW-1:0] c0_q, c1_q, c2_q, t0_q, t1_q, t2_q;
  logic [NS-1:0]  skp;
  logic           is_wait, is_cmd, go;
  int             wl, dllk_c;

  wire            idle = (st == S_IDLE);
  wire [1:0]      ty   = idle ? mem_type : typ_q;
  wire [MRW-1:0]  c0 = idle ? cur_mr0 : c0_q, c1 = idle ? cur_mr1 : c1_q;
  wire [MRW-1:0]  c2 = idle ? cur_mr2 : c2_q, t0 = idle ? tgt_mr0 : t0_q;
  wire [MRW-1:0]  t1 = idle ? tgt_mr1 : t1_q, t2 = idle ? tgt_mr2 : t2_q;
  wire [MRW-1:0]  mask = (ty == 2'd2) ? MRW'(64) : MRW'(1);
  wire            dll_on_tgt = ((t1 & mask) == '0);
  wire            doff = ((c1 & mask) == '0) && !dll_on_tgt;
  wire            nomrd = (MRD_C == 0);

  assign dllk_c = (ty == 2'd0) ? DK2_C : (ty == 2'd1) ? DK3_C : DKG_C;

  always_comb begin
    skp = '0;
    skp[S_IDLE]     = 1'b1;
    skp[S_ERR]      = 1'b1;
    skp[S_DOFF_PRE] = !doff;
    skp[S_DOFF_MRS] = !doff;
    skp[S_DOFF_W]   = !doff || nomrd;
    skp[S_SR_W]     = (SRE_C == 0);
    skp[S_SRX_W]    = (SRX_C == 0);
    skp[S_XS_W]     = (XS_C == 0);
    skp[S_MR2]      = !(ty == 2'd1 && c2 != t2);
    skp[S_MR2_W]    = skp[S_MR2] || nomrd;
    skp[S_MR1]      = (c1 == t1);
    skp[S_MR1_W]    = skp[S_MR1] || nomrd;
    skp[S_MR0]      = (c0 == t0);
    skp[S_MR0_W]    = skp[S_MR0] || nomrd;
    skp[S_RST_A]    = !dll_on_tgt;
    skp[S_RST_W1]   = !dll_on_tgt || nomrd;
    skp[S_RST_B]    = !dll_on_tgt;
    skp[S_RST_W2]   = !dll_on_tgt || (MRD_C + dllk_c == 0);
    skp[S_RST_PRE]  = !dll_on_tgt || ty != 2'd2;
  end

  always_comb begin
    adv = S_DONE;
    for (int i = NS - 1; i >= 0; i--)
      if (i > int'(st) && !skp[i]) adv = st_t'(5'(i));
  end

  assign nx = idle ? ((mem_type == 2'd3) ? S_ERR : adv)
                   : (st == S_DONE || st == S_ERR) ? S_IDLE : adv;

  always_comb
    case (nx)
      S_DOFF_W, S_MR2_W, S_MR1_W, S_MR0_W, S_RST_W1: wl = MRD_C;
      S_SR_W:   wl = SRE_C;
      S_SRX_W:  wl = SRX_C;
      S_XS_W:   wl = XS_C;
      S_RST_W2: wl = MRD_C + dllk_c;
      default:  wl = 0;
    endcase

  assign is_wait = st inside {S_DOFF_W, S_SR_W, S_SRX_W, S_XS_W, S_MR2_W,
                              S_MR1_W, S_MR0_W, S_RST_W1, S_RST_W2};
  assign is_cmd  = !is_wait && !(st inside {S_IDLE, S_CLK, S_TIM, S_DONE, S_ERR});

  always_comb
    if (idle)              go = start;
    else if (is_wait)      go = (wcnt == '0);
    else if (is_cmd)       go = cmd_ready;
    else if (st == S_CLK)  go = clk_ack;
    else if (st == S_TIM)  go = tim_ack;
    else                   go = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      wcnt <= '0;
      typ_q <= '0;
      {c0_q, c1_q, c2_q, t0_q, t1_q, t2_q} <= '0;
    end else begin
      if (idle && start) begin
        typ_q <= mem_type;
        {c0_q, c1_q, c2_q} <= {cur_mr0, cur_mr1, cur_mr2};
        {t0_q, t1_q, t2_q} <= {tgt_mr0, tgt_mr1, tgt_mr2};
      end
      if (go) begin
        st   <= nx;
        wcnt <= (wl > 0) ? WW'(wl - 1) : '0;
      end else if (is_wait) begin
        wcnt <= wcnt - 1'b1;
      end
    end
  end

  assign busy      = !idle;
  assign done      = (st == S_DONE);
  assign error     = (st == S_ERR);
  assign clk_req   = (st == S_CLK);
  assign tim_req   = (st == S_TIM);
  assign cmd_valid = is_cmd;

  always_comb begin
    cmd_sel  = 2'd0;
    cmd_data = '0;
    case (st)
      S_SR_REF1, S_SR_REF2: cmd_op = 3'd1;
      S_SR_AOFF:            cmd_op = 3'd2;
      S_X_AON:              cmd_op = 3'd3;
      S_SR_SON:             cmd_op = 3'd4;
      S_X_SOFF:             cmd_op = 3'd5;
      S_DOFF_MRS: begin cmd_op = 3'd6; cmd_sel = 2'd1; cmd_data = c1_q | mask; end
      S_MR2:      begin cmd_op = 3'd6; cmd_sel = 2'd2; cmd_data = t2_q; end
      S_MR1:      begin cmd_op = 3'd6; cmd_sel = 2'd1; cmd_data = t1_q; end
      S_MR0:      begin cmd_op = 3'd6; cmd_data = t0_q; end
      S_RST_A:    begin cmd_op = 3'd6; cmd_data = t0_q | MRW'(256); end
      S_RST_B:    begin cmd_op = 3'd6; cmd_data = t0_q; end
      default:              cmd_op = 3'd0;
    endcase
  end

  assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_sel) && $stable(cmd_data));
  assert_clk_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clk_req && !clk_ack |=> clk_req);
  assert_tim_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tim_req && !tim_ack |=> tim_req);
  assert_err_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> $past(start) && !$past(busy));
  assert_one_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid, clk_req, tim_req, done, error}));
  assert_busy_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done && !error |=> busy);
endmodule

// File: tb/tb_dram_reclock_seq.sv
module tb_dram_reclock_seq;
  localparam int CLK_NS = 20;
  localparam int SRE_NS = 100;
  localparam int SRX_NS = 0;
  localparam int XS_NS  = 30;

  function automatic int cyc_of(int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0, start = 1'b0;
  logic [1:0]  mem_type = '0;
  logic [15:0] cur_mr0 = '0, cur_mr1 = '0, cur_mr2 = '0;
  logic [15:0] tgt_mr0 = '0, tgt_mr1 = '0, tgt_mr2 = '0;
  logic        busy, done, error, cmd_valid, cmd_ready, clk_req, clk_ack, tim_req, tim_ack;
  logic [2:0]  cmd_op;
  logic [1:0]  cmd_sel;
  logic [15:0] cmd_data;

  logic       stall = 1'b0;
  logic [7:0] lfsr = 8'h5a;
  always @(posedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  wire rdy = stall ? lfsr[0] : 1'b1;
  assign cmd_ready = rdy;
  assign clk_ack   = clk_req & rdy;
  assign tim_ack   = tim_req & rdy;

  dram_reclock_seq #(.CLK_NS(CLK_NS), .SRE_NS(SRE_NS), .SRX_NS(SRX_NS), .XS_NS(XS_NS)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_type(mem_type),
    .cur_mr0(cur_mr0), .cur_mr1(cur_mr1), .cur_mr2(cur_mr2),
    .tgt_mr0(tgt_mr0), .tgt_mr1(tgt_mr1), .tgt_mr2(tgt_mr2),
    .busy(busy), .done(done), .error(error),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_sel(cmd_sel),
    .cmd_data(cmd_data), .clk_req(clk_req), .clk_ack(clk_ack),
    .tim_req(tim_req), .tim_ack(tim_ack));

  typedef struct {int code; int sel; int data; int gap; string req;} ev_t;
  ev_t q[$];
  int checks = 0, errors = 0, cyc = 0, last = 0, pend = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(int code, int sel, int data, string req);
    q.push_back('{code, sel, data, stall ? -1 : pend + 1, req});
    pend = 0;
  endtask

  task automatic got(int code, int sel, int data);
    ev_t e;
    if (q.size() == 0) begin
      chk(1'b0, "R2", "unexpected event", code, -1);
    end else begin
      e = q.pop_front();
      chk(code == e.code, e.req, "event code", code, e.code);
      chk(sel == e.sel, e.req, "register select", sel, e.sel);
      chk(data == e.data, e.req, "register data", data, e.data);
      if (e.gap >= 0) chk(cyc - last == e.gap, e.req, "cycles since previous event", cyc - last, e.gap);
    end
    last = cyc;
  endtask

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (start && !busy) last = cyc;
    if (cmd_valid && cmd_ready) got(int'(cmd_op), int'(cmd_sel), int'(cmd_data));
    if (clk_req && clk_ack) got(8, 0, 0);
    if (tim_req && tim_ack) got(9, 0, 0);
    if (done) got(10, 0, 0);
    if (error) got(11, 0, 0);
  end

  task automatic build(int ty, int c0, int c1, int c2, int t0, int t1, int t2);
    int mask, mrd;
    mask = (ty == 2) ? 'h40 : 'h1;
    mrd  = cyc_of(1000);
    pend = 0;
    if (ty == 3) begin push(11, 0, 0, "R1"); return; end
    if ((c1 & mask) == 0 && (t1 & mask) != 0) begin
      push(0, 0, 0, "R4"); push(6, 1, c1 | mask, "R4"); pend += mrd;
    end
    push(0, 0, 0, "R5"); push(1, 0, 0, "R5"); push(1, 0, 0, "R5");
    push(2, 0, 0, "R5"); push(4, 0, 0, "R5"); pend += cyc_of(SRE_NS);
    push(8, 0, 0, "R6"); pend += cyc_of(SRX_NS);
    push(0, 0, 0, "R7"); push(5, 0, 0, "R7"); push(3, 0, 0, "R7"); pend += cyc_of(XS_NS);
    if (ty == 1 && c2 != t2) begin push(6, 2, t2, "R8"); pend += mrd; end
    if (c1 != t1) begin push(6, 1, t1, "R8"); pend += mrd; end
    if (c0 != t0) begin push(6, 0, t0, "R8"); pend += mrd; end
    push(9, 0, 0, "R9");
    if ((t1 & mask) == 0) begin
      push(6, 0, t0 | 'h100, "R10"); pend += mrd;
      push(6, 0, t0, "R10");
      pend += mrd + cyc_of(ty == 0 ? 2000 : ty == 1 ? 12000 : 40000);
      if (ty == 2) push(0, 0, 0, "R10 R11");
    end
    push(10, 0, 0, "R11");
  endtask

  task automatic run(int ty, int c0, int c1, int c2, int t0, int t1, int t2, bit stl, bit restart);
    stall = stl;
    build(ty, c0, c1, c2, t0, t1, t2);
    @(posedge clk); #2;
    mem_type = 2'(ty);
    cur_mr0 = 16'(c0); cur_mr1 = 16'(c1); cur_mr2 = 16'(c2);
    tgt_mr0 = 16'(t0); tgt_mr1 = 16'(t1); tgt_mr2 = 16'(t2);
    start = 1'b1;
    @(posedge clk); #2 start = 1'b0;
    if (restart) begin
      repeat (20) @(posedge clk);
      #2 start = 1'b1; mem_type = 2'd3; tgt_mr0 = 16'hffff; tgt_mr1 = 16'h0;
      @(posedge clk); #2 start = 1'b0;
    end
    @(negedge clk);
    while (!(done || error)) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R2", "events left unseen", q.size(), 0);
    chk(!busy, "R2", "busy after end of run", int'(busy), 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R2: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !error, "R2", "idle outputs after reset", int'({busy, done, error}), 0);
    chk(!cmd_valid && !clk_req && !tim_req, "R3", "no request after reset",
        int'({cmd_valid, clk_req, tim_req}), 0);
    // R8 R10 R11: DDR2, MR2 differs but is not written, DLL reset with short lock
    run(0, 'h0520, 'h0000, 'h0001, 'h0630, 'h0004, 'h0002, 1'b0, 1'b0);
    // R4 R8: DDR3 switches DLL off, MR2 and MR1 rewritten, no DLL reset
    run(1, 'h1234, 'h0000, 'h0008, 'h1234, 'h0001, 'h0010, 1'b0, 1'b0);
    // R4 R10 R11: GDDR3, bit 0 is not the DLL bit, long lock and final precharge
    run(2, 'h0111, 'h0001, 'h0022, 'h0111, 'h0001, 'h0022, 1'b0, 1'b0);
    // R4 R8: GDDR3 DLL already off, only MR1 rewritten
    run(2, 'h0100, 'h0040, 'h0000, 'h0100, 'h0041, 'h0000, 1'b0, 1'b0);
    // R2 R3 R6 R9: DDR3 with random stalls and a second start while busy
    run(1, 'h0200, 'h0000, 'h0004, 'h0300, 'h0040, 'h0004, 1'b1, 1'b1);
    // R1: unsupported type
    run(3, 'h0000, 'h0000, 'h0000, 'h0001, 'h0001, 'h0001, 1'b0, 1'b0);
    // R4: DDR2 turns DLL off
    run(0, 'h0400, 'h0002, 'h0000, 'h0400, 'h0003, 'h0000, 1'b0, 1'b0);
    finish_run();
  end
endmodule